// File: doc/BRIEF.md
# Fractional-N pulse-swallow divider controller

This block sequences a dual-modulus prescaler (ratio P or P+1, with P equal to 6 or 8) so that the feedback path of a fractional-N synthesizer divides by N = P*B + A + FN/M on average. A divide cycle lasts B prescaler output pulses. The modulus-control output asks for P+1 on the first A' pulses of the cycle and for P on the rest. A' is the swallow value A plus a one-bit carry from a first-order digital accumulator. The accumulator adds the fractional numerator FN once per divide cycle and wraps modulo M. M is 1920 or 1968, chosen by a reference-select bit, so one FN step is one 10 kHz channel step.

The block is clocked by a fast system clock. A one-cycle strobe marks each prescaler output pulse. Programmed values can change at any time, but they take effect only at the next divide-cycle boundary. Out-of-range values are clamped to the nearest legal setting, and an error flag reports them.

Top module: `fracn_swallow_ctrl`

## Requirements
- R1: Over any M consecutive divide cycles that use one setting, the sum of prescaler input periods equals M*(P*B + A) + FN. A pulse seen with mod_hi=1 counts P+1 periods, and one seen with mod_hi=0 counts P. P is 8 when p8_act=1 and 6 when it is 0.
- R2: M is 1920 when ref_in=0 and 1968 when ref_in=1.
- R3: A divide cycle is exactly B pulses long. mod_hi is 1 for the first A' pulses and 0 for the rest, so it never rises again inside a cycle. A' equals A plus the carry_out value held during that cycle.
- R4: The accumulator adds FN at each cycle boundary. When the sum reaches M, it subtracts M and sets carry_out to 1 for the cycle that starts there. Over M cycles carry_out is 1 in exactly FN of them. When the selected modulus changes at a boundary, the accumulator restarts from zero.
- R5: B, A', FN and the prescaler select (p8_in) are sampled only on the clock edge that consumes the last pulse of a cycle (cyc_done=1). A change made mid-cycle does not affect the current cycle. A change present on that edge governs the following cycle.
- R6: cfg_err=1 (combinational) when b_in<2, a_in>=b_in, a_in>P-1 (P from p8_in), or fn_in>=M. Clamping forces B to at least 2, A to at most min(B-1, P-1), and FN to at most M-1.
- R7: A clock without pre_pulse changes no state, and cyc_done stays 0.
- R8: After reset, mod_hi=0, carry_out=0 and p8_act=0. The first cycle is 2 pulses long, regardless of the inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pre_pulse | input | 1 | One-clock strobe per prescaler output pulse |
| b_in | input | 4 | Programmable counter B |
| a_in | input | 3 | Swallow counter A |
| fn_in | input | 11 | Fractional numerator FN |
| p8_in | input | 1 | Prescaler select: 1 = 8/9, 0 = 6/7 |
| ref_in | input | 1 | Modulus select: 0 = 1920, 1 = 1968 |
| mod_hi | output | 1 | Modulus control: 1 requests P+1 for the current pulse |
| cyc_done | output | 1 | The current pulse ends the divide cycle |
| carry_out | output | 1 | Accumulator carry in effect for this cycle |
| p8_act | output | 1 | Prescaler select in effect for this cycle |
| cfg_err | output | 1 | Programmed values out of range |

## Verification
The cycle boundary loads the new B, A' and prescaler select and also steps the accumulator, and a software change to the settings can land on that same edge. The bench applies new values exactly on the clock that consumes the last pulse, and again in the middle of a cycle. It judges the lengths and wide-pulse counts of the cycle just ending and of the next one. A second coincidence is a carry arriving when A already equals B-1, which makes every pulse of the cycle wide (A'=B). A window with B=2, A=1 and FN near M provokes it, and the period total over M cycles judges it.

// File: rtl/fnd_pkg.sv
package fnd_pkg;
  function automatic int pick(input logic sel, input int when0, input int when1);
    return sel ? when1 : when0;
  endfunction

  function automatic int floor_at(input int v, input int lo);
    return (v < lo) ? lo : v;
  endfunction

  function automatic int ceil_at(input int v, input int hi);
    return (v > hi) ? hi : v;
  endfunction

  function automatic int min2(input int x, input int y);
    return (x < y) ? x : y;
  endfunction
endpackage

// File: rtl/fnd_cfg_clamp.sv
module fnd_cfg_clamp
  import fnd_pkg::*;
#(
  parameter int B_W    = 4,
  parameter int A_W    = 3,
  parameter int FN_W   = 11,
  parameter int MOD_LO = 1920,
  parameter int MOD_HI = 1968,
  parameter int PRE_LO = 6,
  parameter int PRE_HI = 8,
  parameter int B_MIN  = 2
) (
  input  logic [B_W-1:0]  b_in,
  input  logic [A_W-1:0]  a_in,
  input  logic [FN_W-1:0] fn_in,
  input  logic            p8_in,
  input  logic            ref_in,
  output logic [B_W-1:0]  b_c,
  output logic [A_W-1:0]  a_c,
  output logic [FN_W-1:0] fn_c,
  output logic [FN_W-1:0] mod_val,
  output logic            cfg_err
);
  int pre_i, mod_i, b_i, a_i, f_i;

  always_comb begin
    pre_i   = pick(p8_in, PRE_LO, PRE_HI);
    mod_i   = pick(ref_in, MOD_LO, MOD_HI);
    b_i     = floor_at(int'(b_in), B_MIN);
    a_i     = ceil_at(int'(a_in), min2(b_i - 1, pre_i - 1));
    f_i     = ceil_at(int'(fn_in), mod_i - 1);
    b_c     = B_W'(b_i);
    a_c     = A_W'(a_i);
    fn_c    = FN_W'(f_i);
    mod_val = FN_W'(mod_i);
    cfg_err = (int'(b_in) < B_MIN) || (int'(a_in) >= int'(b_in)) ||
              (int'(a_in) >= pre_i) || (int'(fn_in) >= mod_i);
  end

  always_comb begin
    if (!$isunknown({b_in, a_in, fn_in, p8_in, ref_in})) begin
      // R6
      pass_through_chk: assert (cfg_err || (b_c == b_in && a_c == a_in && fn_c == fn_in));
    end
  end
endmodule

// File: rtl/fnd_dsm_acc.sv
module fnd_dsm_acc #(
  parameter int FN_W    = 11,
  parameter int MOD_RST = 1920
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            step,
  input  logic [FN_W-1:0] fn_c,
  input  logic [FN_W-1:0] mod_val,
  output logic            carry_nxt,
  output logic            carry_q
);
  logic [FN_W-1:0] acc_q, mod_q, base;
  logic [FN_W:0]   sum;

  always_comb begin
    base      = (mod_val == mod_q) ? acc_q : '0;
    sum       = {1'b0, base} + {1'b0, fn_c};
    carry_nxt = (sum >= {1'b0, mod_val});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q   <= '0;
      mod_q   <= FN_W'(MOD_RST);
      carry_q <= 1'b0;
    end else if (step) begin
      acc_q   <= carry_nxt ? FN_W'(sum - {1'b0, mod_val}) : sum[FN_W-1:0];
      mod_q   <= mod_val;
      carry_q <= carry_nxt;
    end
  end

  // R4
  acc_range_chk: assert property (@(posedge clk) disable iff (!rst_n) acc_q < mod_q);
  // R7
  acc_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> ($stable(acc_q) && $stable(carry_q)));
endmodule

// File: rtl/fnd_swallow_cnt.sv
module fnd_swallow_cnt #(
  parameter int B_W   = 4,
  parameter int B_MIN = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           pulse,
  input  logic [B_W-1:0] b_c,
  input  logic [B_W-1:0] a_eff_nxt,
  input  logic           p8_in,
  output logic           mod_hi,
  output logic           last_pulse,
  output logic           p8_q
);
  logic [B_W-1:0] cnt_q, b_q, ae_q;

  assign last_pulse = pulse && (cnt_q == b_q - B_W'(1));
  assign mod_hi     = (cnt_q < ae_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      b_q   <= B_W'(B_MIN);
      ae_q  <= '0;
      p8_q  <= 1'b0;
    end else if (pulse) begin
      if (last_pulse) begin
        cnt_q <= '0;
        b_q   <= b_c;
        ae_q  <= a_eff_nxt;
        p8_q  <= p8_in;
      end else begin
        cnt_q <= cnt_q + B_W'(1);
      end
    end
  end

  // R3
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n) cnt_q < b_q);
  // R3
  mod_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse && !mod_hi && !last_pulse) |=> !mod_hi);
  // R5
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !last_pulse |=> ($stable(b_q) && $stable(ae_q) && $stable(p8_q)));
  // R5
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_pulse |=> (cnt_q == '0));
  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pulse |=> $stable(cnt_q));
  // R6
  b_floor_chk: assert property (@(posedge clk) disable iff (!rst_n) b_q >= B_W'(B_MIN));
endmodule

// File: rtl/fracn_swallow_ctrl.sv
module fracn_swallow_ctrl #(
  parameter int B_W    = 4,
  parameter int A_W    = 3,
  parameter int FN_W   = 11,
  parameter int MOD_LO = 1920,
  parameter int MOD_HI = 1968,
  parameter int PRE_LO = 6,
  parameter int PRE_HI = 8,
  parameter int B_MIN  = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pre_pulse,
  input  logic [B_W-1:0]  b_in,
  input  logic [A_W-1:0]  a_in,
  input  logic [FN_W-1:0] fn_in,
  input  logic            p8_in,
  input  logic            ref_in,
  output logic            mod_hi,
  output logic            cyc_done,
  output logic            carry_out,
  output logic            p8_act,
  output logic            cfg_err
);
  logic [B_W-1:0]  b_c, a_eff_nxt;
  logic [A_W-1:0]  a_c;
  logic [FN_W-1:0] fn_c, mod_val;
  logic            carry_nxt;

  fnd_cfg_clamp #(
    .B_W(B_W), .A_W(A_W), .FN_W(FN_W), .MOD_LO(MOD_LO), .MOD_HI(MOD_HI),
    .PRE_LO(PRE_LO), .PRE_HI(PRE_HI), .B_MIN(B_MIN)
  ) u_clamp (
    .b_in(b_in), .a_in(a_in), .fn_in(fn_in), .p8_in(p8_in), .ref_in(ref_in),
    .b_c(b_c), .a_c(a_c), .fn_c(fn_c), .mod_val(mod_val), .cfg_err(cfg_err)
  );

  fnd_dsm_acc #(.FN_W(FN_W), .MOD_RST(MOD_LO)) u_dsm (
    .clk(clk), .rst_n(rst_n), .step(cyc_done), .fn_c(fn_c), .mod_val(mod_val),
    .carry_nxt(carry_nxt), .carry_q(carry_out)
  );

  assign a_eff_nxt = {{(B_W-A_W){1'b0}}, a_c} + {{(B_W-1){1'b0}}, carry_nxt};

  fnd_swallow_cnt #(.B_W(B_W), .B_MIN(B_MIN)) u_cnt (
    .clk(clk), .rst_n(rst_n), .pulse(pre_pulse), .b_c(b_c), .a_eff_nxt(a_eff_nxt),
    .p8_in(p8_in), .mod_hi(mod_hi), .last_pulse(cyc_done), .p8_q(p8_act)
  );

  // R3
  carry_wide_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_done && carry_nxt) |=> mod_hi);
endmodule

// File: tb/fracn_swallow_ctrl_test.sv
`timescale 1ns/1ps
module fracn_swallow_ctrl_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pre_pulse = 1'b0;
  logic [3:0]  b_in = 4'd3;
  logic [2:0]  a_in = 3'd1;
  logic [10:0] fn_in = 11'd0;
  logic p8_in = 1'b0, ref_in = 1'b0;
  logic mod_hi, cyc_done, carry_out, p8_act, cfg_err;

  int n_chk = 0, n_err = 0;
  int pin = 0, hin = 0, last_len = 0, cyc_cnt = 0, per_sum = 0, car_sum = 0;
  bit low_seen = 0, order_bad = 0;
  int exp_b = 2, exp_a = 0;
  bit exp_p8 = 0;
  bit run = 0, sparse = 0;

  fracn_swallow_ctrl uut (
    .clk(clk), .rst_n(rst_n), .pre_pulse(pre_pulse), .b_in(b_in), .a_in(a_in),
    .fn_in(fn_in), .p8_in(p8_in), .ref_in(ref_in), .mod_hi(mod_hi),
    .cyc_done(cyc_done), .carry_out(carry_out), .p8_act(p8_act), .cfg_err(cfg_err)
  );

  always #5 clk = ~clk;

  function automatic int m_of(bit r); return r ? 1968 : 1920; endfunction
  function automatic int p_of(bit p8); return p8 ? 8 : 6; endfunction
  function automatic int eb_of(int b); return (b >= 2) ? b : 2; endfunction
  function automatic int ea_of(int a, int b, bit p8);
    int r = a;
    if (r >= eb_of(b)) r = eb_of(b) - 1;
    if (r >= p_of(p8)) r = p_of(p8) - 1;
    return r;
  endfunction
  function automatic int ef_of(int fn, bit r);
    return (fn < m_of(r)) ? fn : m_of(r) - 1;
  endfunction
  function automatic bit err_of(int b, int a, int fn, bit p8, bit r);
    return !(b >= 2 && a < b && a < p_of(p8) && fn < m_of(r));
  endfunction

  task automatic check(input bit ok, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  // pulse source
  always @(posedge clk) begin
    #1;
    if (!run) pre_pulse = 1'b0;
    else if (sparse) pre_pulse = ($urandom_range(1, 0) == 1);
    else pre_pulse = 1'b1;
  end

  // monitor: models the prescaler input periods and judges each divide cycle
  always @(negedge clk) begin
    if (rst_n) begin
      if (!pre_pulse) begin
        if (cyc_done) check(0, "R7 cyc_done without pulse", 1, 0);
      end else begin
        pin = pin + 1;
        if (mod_hi) begin
          hin = hin + 1;
          if (low_seen) order_bad = 1;
        end else low_seen = 1;
        per_sum = per_sum + p_of(p8_act) + (mod_hi ? 1 : 0);
        if (cyc_done) begin
          check(pin == exp_b, "R5 cycle length", pin, exp_b);
          check(hin == exp_a + int'(carry_out), "R3 wide pulse count", hin, exp_a + int'(carry_out));
          check(!order_bad, "R3 wide pulses first", int'(order_bad), 0);
          check(p8_act == exp_p8, "R5 prescaler select", int'(p8_act), int'(exp_p8));
          car_sum = car_sum + int'(carry_out);
          exp_b  = eb_of(int'(b_in));
          exp_a  = ea_of(int'(a_in), int'(b_in), p8_in);
          exp_p8 = p8_in;
          last_len = pin;
          pin = 0; hin = 0; low_seen = 0; order_bad = 0;
          cyc_cnt = cyc_cnt + 1;
        end
      end
    end
  end

  task automatic set_cfg(input int b, input int a, input int fn, input bit p8, input bit r);
    b_in = 4'(b); a_in = 3'(a); fn_in = 11'(fn); p8_in = p8; ref_in = r;
  endtask

  task automatic window(input int b, input int a, input int fn, input bit p8, input bit r);
    int c0, t0, k0, m, expect_tot;
    @(posedge clk); #1;
    set_cfg(b, a, fn, p8, r);
    c0 = cyc_cnt;
    wait (cyc_cnt != c0);
    c0 = cyc_cnt; t0 = per_sum; k0 = car_sum;
    m = m_of(r);
    expect_tot = m * (p_of(p8) * eb_of(b) + ea_of(a, b, p8)) + ef_of(fn, r);
    wait (cyc_cnt == c0 + m);
    check(per_sum - t0 == expect_tot, "R1 R2 period total over M cycles", per_sum - t0, expect_tot);
    check(car_sum - k0 == ef_of(fn, r), "R4 carries over M cycles", car_sum - k0, ef_of(fn, r));
  endtask

  task automatic err_case(input int b, input int a, input int fn, input bit p8, input bit r);
    @(posedge clk); #1;
    set_cfg(b, a, fn, p8, r);
    @(negedge clk);
    check(cfg_err == err_of(b, a, fn, p8, r), "R6 error flag", int'(cfg_err), int'(err_of(b, a, fn, p8, r)));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_run();
  end

  initial begin
    int c0, nb, hold_ok;
    bit m0, k0, p0;
    void'($urandom(32'd20231));
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R8 reset state
    check(mod_hi == 1'b0, "R8 mod_hi after reset", int'(mod_hi), 0);
    check(carry_out == 1'b0, "R8 carry after reset", int'(carry_out), 0);
    check(p8_act == 1'b0, "R8 prescaler after reset", int'(p8_act), 0);
    check(cyc_done == 1'b0, "R8 no cycle end after reset", int'(cyc_done), 0);
    @(posedge clk); #1 run = 1;
    wait (cyc_cnt == 1);
    check(last_len == 2, "R8 first cycle length", last_len, 2);

    window(15, 7, 1919, 1'b1, 1'b0);
    window(2, 1, 1967, 1'b0, 1'b1);

    // R5 mid-cycle change
    @(posedge clk); #1 set_cfg(10, 3, 0, 1'b1, 1'b0);
    c0 = cyc_cnt; wait (cyc_cnt == c0 + 2);
    forever begin @(posedge clk); if (pin == 5) break; end
    #1 set_cfg(4, 0, 0, 1'b1, 1'b0);
    c0 = cyc_cnt; wait (cyc_cnt == c0 + 1);
    check(last_len == 10, "R5 mid-cycle change ignored", last_len, 10);
    wait (cyc_cnt == c0 + 2);
    check(last_len == 4, "R5 new length next cycle", last_len, 4);

    // R5 change on the edge that consumes the last pulse
    forever begin @(posedge clk); if (pin == exp_b - 1) break; end
    #1 set_cfg(7, 2, 500, 1'b0, 1'b0);
    c0 = cyc_cnt; wait (cyc_cnt == c0 + 1);
    check(last_len == 4, "R5 boundary cycle keeps old length", last_len, 4);
    wait (cyc_cnt == c0 + 2);
    check(last_len == 7, "R5 boundary change takes effect", last_len, 7);

    // R6 directed and random error cases
    err_case(1, 0, 0, 1'b0, 1'b0);
    err_case(5, 5, 0, 1'b1, 1'b0);
    err_case(15, 6, 0, 1'b0, 1'b0);
    err_case(15, 6, 0, 1'b1, 1'b0);
    err_case(9, 3, 1920, 1'b0, 1'b0);
    err_case(9, 3, 1920, 1'b0, 1'b1);
    err_case(9, 3, 1968, 1'b0, 1'b1);
    err_case(2, 1, 1919, 1'b1, 1'b0);
    for (int i = 0; i < 30; i++)
      err_case($urandom_range(15, 0), $urandom_range(7, 0), $urandom_range(2047, 0),
               1'($urandom_range(1, 0)), 1'($urandom_range(1, 0)));

    // R6 clamped window
    window(1, 3, 2000, 1'b0, 1'b0);

    // R7 pulses stop
    @(posedge clk); #1 run = 0;
    repeat (2) @(negedge clk);
    m0 = mod_hi; k0 = carry_out; p0 = p8_act; hold_ok = 1;
    repeat (10) begin
      @(negedge clk);
      if (mod_hi != m0 || carry_out != k0 || p8_act != p0 || cyc_done) hold_ok = 0;
    end
    check(hold_ok == 1, "R7 state held without pulses", hold_ok, 1);
    @(posedge clk); #1 run = 1; sparse = 1;
    window(5, 2, 960, 1'b1, 1'b1);
    sparse = 0;

    for (int i = 0; i < 2; i++) begin
      bit p8r = 1'($urandom_range(1, 0));
      bit rr  = 1'($urandom_range(1, 0));
      nb = $urandom_range(8, 2);
      window(nb, $urandom_range(nb - 1, 0) % p_of(p8r), $urandom_range(m_of(rr) - 1, 0), p8r, rr);
    end
    finish_run();
  end
endmodule